// File: doc/BRIEF.md
# MDIO Management Master

This block runs the controller side of a clause-22 style management bus. The host supplies a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. The block then produces a complete serial frame. It drives an MDC clock output and a data line made of three pins: an output value, an output enable and a separately synchronised input.

MDC comes from an internal divider. Its half period is a parameter counted in system clocks, so the output can be kept at or below 2.5 MHz. MDC rests low whenever the block is idle.

Each frame has four parts, in this order:
- a preamble of ones;
- start, opcode and address bits;
- a turnaround;
- sixteen data bits.

Reads end with two released clock periods. Writes end with one released period. If the PHY does not pull the line low in the turnaround of a read, the block gives up on that read. It clocks 32 recovery periods with the line released, then reports an error.

The sequencer is one state machine with these states:
- `ST_IDLE`: waiting for a request.
- `ST_PREAMBLE`, `ST_START`, `ST_OPCODE`, `ST_PHYADR` and `ST_REGADR`: the common frame head.
- `ST_WR_TA`, `ST_WR_DATA` and `ST_WR_TAIL`: the write path.
- `ST_RD_TA`, `ST_RD_DATA` and `ST_RD_TAIL`: the read path.
- `ST_RECOVER`: the abort path.

Each state lasts a fixed number of MDC periods. At the end of the last period of a state, the machine takes one of these transitions:
- `ST_IDLE` to `ST_PREAMBLE` when a request is accepted.
- Straight through the head, from `ST_PREAMBLE` to `ST_REGADR`.
- From `ST_REGADR` to `ST_RD_TA` or `ST_WR_TA`, depending on the operation.
- From `ST_RD_TA` to `ST_RD_DATA` if the turnaround sample is low, or to `ST_RECOVER` if it is high.
- From `ST_RD_DATA` to `ST_RD_TAIL`.
- From `ST_WR_TA` to `ST_WR_DATA`, then to `ST_WR_TAIL`.
- From `ST_RD_TAIL`, `ST_WR_TAIL` or `ST_RECOVER` back to `ST_IDLE`, with a done pulse.

Top module: `mdio_master`

## Requirements
- R1: After a request is accepted, the first 32 MDC rising edges each see mdio_oe=1 and mdio_o=1.
- R2: The next 14 rising edges carry, in order:
  - the start pair 0,1;
  - the opcode (1,0 for a read, 0,1 for a write);
  - the PHY address, MSB first;
  - the register address, MSB first.
- R3: mdio_o and mdio_oe change only in system clock cycles where mdc is low.
- R4: One MDC period lasts 2*HALF_DIV system clocks. mdc is low whenever busy is low.
- R5: On a read, rising edge 47 sees mdio_oe=0. If the line is sampled at 0 while MDC is high, the next 16 edges capture read data MSB first, with mdio_oe=0, and the data appears on rdata at done.
- R6: A successful read continues for two more released rising edges, so a read frame has 65 rising edges in total. err is 0 at done.
- R7: If the turnaround sample of a read is 1, the block clocks 32 more rising edges with mdio_oe=0 (79 in total). done then carries err=1 and rdata=0.
- R8: On a write, edges 47 and 48 carry the turnaround 1,0 and edges 49 to 64 carry the write data MSB first. Edge 65 is released (mdio_oe=0), a write frame has 65 rising edges, and err is 0 at done.
- R9: req_valid is accepted only while busy is low, and busy rises in the following cycle. A request presented while busy is high has no effect on the frame in flight and causes no second done.
- R10: done is a single-cycle pulse raised in the cycle busy falls. err changes only at done, where it may rise, and at an accepted request, where it clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_read | input | 1 | 1 selects read, 0 selects write |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Data for a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last read saw no turnaround response |
| rdata | output | 16 | Data from the last successful read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line value from the pad |

## Verification
A wrong slot count or a wrong state transition shifts or truncates the bit pattern seen on the pins. The bench records mdio_oe and mdio_o at every MDC rise, so such a fault appears within one MDC period of where it occurs, and the total rise count at done exposes it again. A wrong shift or capture register shows up as a header or data bit mismatch, or as a wrong rdata at the same done. A broken turnaround decision moves the frame length from 65 to 79 rises, or the reverse, and flips err.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    localparam int PHY_W  = 5;
    localparam int REG_W  = 5;
    localparam int DATA_W = 16;
    localparam int HDR_W  = 2 + 2 + PHY_W + REG_W;
    localparam int TX_W   = HDR_W + 2 + DATA_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_START,
        ST_OPCODE,
        ST_PHYADR,
        ST_REGADR,
        ST_WR_TA,
        ST_WR_DATA,
        ST_WR_TAIL,
        ST_RD_TA,
        ST_RD_DATA,
        ST_RD_TAIL,
        ST_RECOVER
    } mdio_state_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
    parameter int HALF_DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic slot_end
);
    localparam int CNT_W = $clog2(HALF_DIV + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            ph_q  <= ~ph_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc      = ph_q;
    assign slot_end = run && ph_q && (cnt_q == LAST);
endmodule

// File: rtl/mdio_in_sync.sv
`timescale 1ns/1ps
module mdio_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int PRE_LEN   = 32,
    parameter int RECOV_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_read,
    input  logic [PHY_W-1:0]  req_phy,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              slot_end,
    input  logic              line_in,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              line_o,
    output logic              line_oe
);
    localparam int MAXLEN0 = (PRE_LEN > RECOV_LEN) ? PRE_LEN : RECOV_LEN;
    localparam int MAXLEN  = (MAXLEN0 > DATA_W) ? MAXLEN0 : DATA_W;
    localparam int SLOT_W  = $clog2(MAXLEN + 1);

    mdio_state_e       state_q, state_d;
    logic [SLOT_W-1:0] cnt_q, cnt_d;
    logic [TX_W-1:0]   tx_q;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rd_q;
    logic              done_q;
    logic              err_q;
    logic              accept;
    logic              last_slot;
    logic              shift_tx;

    function automatic logic [SLOT_W-1:0] slots_of(input mdio_state_e s);
        unique case (s)
            ST_PREAMBLE: slots_of = SLOT_W'(PRE_LEN - 1);
            ST_START:    slots_of = SLOT_W'(1);
            ST_OPCODE:   slots_of = SLOT_W'(1);
            ST_PHYADR:   slots_of = SLOT_W'(PHY_W - 1);
            ST_REGADR:   slots_of = SLOT_W'(REG_W - 1);
            ST_WR_TA:    slots_of = SLOT_W'(1);
            ST_WR_DATA:  slots_of = SLOT_W'(DATA_W - 1);
            ST_WR_TAIL:  slots_of = SLOT_W'(0);
            ST_RD_TA:    slots_of = SLOT_W'(0);
            ST_RD_DATA:  slots_of = SLOT_W'(DATA_W - 1);
            ST_RD_TAIL:  slots_of = SLOT_W'(1);
            ST_RECOVER:  slots_of = SLOT_W'(RECOV_LEN - 1);
            default:     slots_of = SLOT_W'(0);
        endcase
    endfunction

    function automatic mdio_state_e next_of(input mdio_state_e s,
                                            input logic rd,
                                            input logic ta_high);
        unique case (s)
            ST_PREAMBLE: next_of = ST_START;
            ST_START:    next_of = ST_OPCODE;
            ST_OPCODE:   next_of = ST_PHYADR;
            ST_PHYADR:   next_of = ST_REGADR;
            ST_REGADR:   next_of = rd ? ST_RD_TA : ST_WR_TA;
            ST_WR_TA:    next_of = ST_WR_DATA;
            ST_WR_DATA:  next_of = ST_WR_TAIL;
            ST_RD_TA:    next_of = ta_high ? ST_RECOVER : ST_RD_DATA;
            ST_RD_DATA:  next_of = ST_RD_TAIL;
            default:     next_of = ST_IDLE;
        endcase
    endfunction

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign last_slot = slot_end && (cnt_q == '0);
    assign shift_tx  = slot_end && (state_q inside {ST_START, ST_OPCODE, ST_PHYADR,
                                                    ST_REGADR, ST_WR_TA, ST_WR_DATA});

    // next state and slot counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (state_q == ST_IDLE) begin
            if (accept) begin
                state_d = ST_PREAMBLE;
                cnt_d   = slots_of(ST_PREAMBLE);
            end
        end else if (slot_end) begin
            if (cnt_q == '0) begin
                state_d = next_of(state_q, rd_q, line_in);
                cnt_d   = slots_of(state_d);
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // frame datapath: shift registers and completion flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q    <= '0;
            rx_q    <= '0;
            rdata_q <= '0;
            rd_q    <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                rd_q  <= req_read;
                err_q <= 1'b0;
                tx_q  <= {2'b01, (req_read ? 2'b10 : 2'b01), req_phy, req_reg,
                          2'b10, req_wdata};
            end else if (shift_tx) begin
                tx_q <= {tx_q[TX_W-2:0], 1'b0};
            end
            if (slot_end && state_q == ST_RD_DATA) begin
                rx_q <= {rx_q[DATA_W-2:0], line_in};
            end
            if (last_slot) begin
                unique case (state_q)
                    ST_RD_TAIL: begin
                        done_q  <= 1'b1;
                        rdata_q <= rx_q;
                    end
                    ST_WR_TAIL: begin
                        done_q <= 1'b1;
                    end
                    ST_RECOVER: begin
                        done_q  <= 1'b1;
                        err_q   <= 1'b1;
                        rdata_q <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // pin outputs decoded from state
    always_comb begin
        line_o  = 1'b0;
        line_oe = 1'b0;
        unique case (state_q)
            ST_PREAMBLE: begin
                line_oe = 1'b1;
                line_o  = 1'b1;
            end
            ST_START, ST_OPCODE, ST_PHYADR, ST_REGADR, ST_WR_TA, ST_WR_DATA: begin
                line_oe = 1'b1;
                line_o  = tx_q[TX_W-1];
            end
            ST_IDLE, ST_WR_TAIL, ST_RD_TA, ST_RD_DATA, ST_RD_TAIL, ST_RECOVER: begin
                line_oe = 1'b0;
                line_o  = 1'b0;
            end
            default: begin
                line_oe = 1'b0;
                line_o  = 1'b0;
            end
        endcase
    end

    assign busy  = (state_q != ST_IDLE);
    assign done  = done_q;
    assign err   = err_q;
    assign rdata = rdata_q;
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV    = 20,
    parameter int SYNC_STAGES = 2,
    parameter int PRE_LEN     = 32,
    parameter int RECOV_LEN   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_read,
    input  logic [PHY_W-1:0]  req_phy,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic slot_end;
    logic mdio_s;
    logic busy_w;

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy_w),
        .mdc      (mdc),
        .slot_end (slot_end)
    );

    mdio_in_sync #(.STAGES(SYNC_STAGES)) u_in_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (mdio_i),
        .dout  (mdio_s)
    );

    mdio_frame_seq #(.PRE_LEN(PRE_LEN), .RECOV_LEN(RECOV_LEN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_read  (req_read),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .slot_end  (slot_end),
        .line_in   (mdio_s),
        .busy      (busy_w),
        .done      (done),
        .err       (err),
        .rdata     (rdata),
        .line_o    (mdio_o),
        .line_oe   (mdio_oe)
    );

    assign busy = busy_w;
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic err,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    a_r3_pins_move_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc);

    a_r4_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r10_err_rise_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    a_r10_err_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> $past(req_valid && !busy));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int MAXRISE    = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_read = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, err, mdc, mdio_o, mdio_oe;
    logic [15:0] rdata;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    int     rise_n;
    logic   cap_oe [MAXRISE];
    logic   cap_o  [MAXRISE];
    longint cap_cyc[MAXRISE];
    longint cyc = 0;
    int     dones = 0;

    bit          phy_present = 1'b1;
    bit          phy_read = 1'b0;
    logic [15:0] phy_data = '0;

    logic exp_oe[MAXRISE];
    logic exp_o [MAXRISE];
    int   exp_n;

    mdio_master #(.HALF_DIV(HALF)) u_mdio_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (done) dones <= dones + 1;
    end

    // pin recorder and PHY model: the PHY answers on each MDC rise
    always @(posedge mdc) begin
        if (rise_n < MAXRISE) begin
            cap_oe[rise_n]  = mdio_oe;
            cap_o[rise_n]   = mdio_o;
            cap_cyc[rise_n] = cyc;
        end
        rise_n = rise_n + 1;
        #1;
        if (phy_read && phy_present && rise_n == 47)
            mdio_i = 1'b0;
        else if (phy_read && phy_present && rise_n >= 48 && rise_n <= 63)
            mdio_i = phy_data[63 - rise_n];
        else
            mdio_i = 1'b1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint got, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, expv);
        end
    endtask

    function automatic int frame_len(input bit rd, input bit present);
        if (rd && !present) return 79;
        return 65;
    endfunction

    task automatic build_expect(input bit rd, input bit present, input logic [4:0] phy,
                                input logic [4:0] rg, input logic [15:0] wd);
        logic [13:0] hdr;
        hdr   = {2'b01, (rd ? 2'b10 : 2'b01), phy, rg};
        exp_n = frame_len(rd, present);
        for (int i = 0; i < MAXRISE; i++) begin
            exp_oe[i] = 1'b0;
            exp_o[i]  = 1'b0;
        end
        for (int i = 0; i < 32; i++) begin
            exp_oe[i] = 1'b1; exp_o[i] = 1'b1;
        end
        for (int i = 0; i < 14; i++) begin
            exp_oe[32+i] = 1'b1; exp_o[32+i] = hdr[13-i];
        end
        if (!rd) begin
            exp_oe[46] = 1'b1; exp_o[46] = 1'b1;
            exp_oe[47] = 1'b1; exp_o[47] = 1'b0;
            for (int i = 0; i < 16; i++) begin
                exp_oe[48+i] = 1'b1; exp_o[48+i] = wd[15-i];
            end
        end
    endtask

    // one transaction; optional interfering request while busy
    task automatic run_txn(input bit rd, input bit present, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] wd,
                           input logic [15:0] pdata, input bit poke,
                           input logic [15:0] prev_rdata);
        int   wait_n;
        int   bad_slot;
        int   dones0;
        logic [15:0] exp_rd;
        build_expect(rd, present, phy, rg, wd);
        phy_read    = rd;
        phy_present = present;
        phy_data    = pdata;
        rise_n      = 0;
        dones0      = dones;
        @(negedge clk);
        req_valid = 1'b1; req_read = rd; req_phy = phy; req_reg = rg; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy === 1'b1, "R9", "busy after accept", busy, 1);
        if (poke) begin
            repeat (100) @(negedge clk);
            req_valid = 1'b1; req_read = ~rd; req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait_n = 0;
        while (done !== 1'b1 && wait_n < 5000) begin
            @(negedge clk);
            wait_n++;
        end
        check(done === 1'b1, "R10", "done seen", done, 1);
        check(busy === 1'b0, "R10", "busy low at done", busy, 0);
        check(rise_n == exp_n, rd ? (present ? "R6" : "R7") : "R8", "MDC rise count",
              rise_n, exp_n);
        bad_slot = -1;
        for (int i = 0; i < exp_n && i < MAXRISE; i++) begin
            if (bad_slot < 0 && (cap_oe[i] !== exp_oe[i] ||
                (exp_oe[i] && cap_o[i] !== exp_o[i])))
                bad_slot = i;
        end
        if (bad_slot >= 0)
            check(1'b0, bad_slot < 32 ? "R1" : (bad_slot < 46 ? "R2" : (rd ? "R5" : "R8")),
                  $sformatf("pins at rise %0d {oe,o}", bad_slot + 1),
                  {cap_oe[bad_slot], cap_o[bad_slot]}, {exp_oe[bad_slot], exp_o[bad_slot]});
        else
            check(1'b1, "R2", "frame pins", 0, 0);
        check(cap_cyc[1] - cap_cyc[0] == 2*HALF, "R4", "MDC period", cap_cyc[1] - cap_cyc[0],
              2*HALF);
        if (rd && present)       exp_rd = pdata;
        else if (rd && !present) exp_rd = 16'h0000;
        else                     exp_rd = prev_rdata;
        check(rdata === exp_rd, rd ? (present ? "R5" : "R7") : "R8", "rdata", rdata, exp_rd);
        check(err === (rd && !present), rd ? "R7" : "R8", "err at done", err,
              (rd && !present));
        repeat (3*2*HALF) @(negedge clk);
        check(mdc === 1'b0 && rise_n == exp_n, "R4", "MDC idle after done", rise_n, exp_n);
        check(dones == dones0 + 1, "R9", "one done per frame", dones - dones0, 1);
        check(err === (rd && !present), "R10", "err held after done", err, (rd && !present));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] last_rd;
        void'($urandom(32'h1d2c3b4a));
        rise_n = 0;
        repeat (5) @(negedge clk);
        // reset state
        check(busy === 1'b0 && done === 1'b0, "R9", "reset busy/done", {busy, done}, 0);
        check(mdc === 1'b0 && mdio_oe === 1'b0, "R4", "reset mdc/oe", {mdc, mdio_oe}, 0);
        check(err === 1'b0 && rdata === 16'h0, "R10", "reset err/rdata", {err, rdata}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        last_rd = 16'h0000;

        // directed corners
        run_txn(1'b0, 1'b1, 5'h1f, 5'h00, 16'h8001, 16'h0, 1'b0, last_rd);
        run_txn(1'b1, 1'b1, 5'h00, 5'h1f, 16'h0, 16'hA55A, 1'b0, last_rd);
        last_rd = 16'hA55A;
        run_txn(1'b1, 1'b0, 5'h15, 5'h0a, 16'h0, 16'hFFFF, 1'b0, last_rd);  // R7 abort
        last_rd = 16'h0000;
        run_txn(1'b1, 1'b1, 5'h0a, 5'h15, 16'h0, 16'hFFFF, 1'b0, last_rd);  // R10 err clears
        last_rd = 16'hFFFF;
        run_txn(1'b0, 1'b1, 5'h03, 5'h1c, 16'h1234, 16'h0, 1'b1, last_rd); // R9 poke
        run_txn(1'b1, 1'b1, 5'h11, 5'h02, 16'h0, 16'h0001, 1'b1, last_rd); // R9 poke on read
        last_rd = 16'h0001;

        // constrained random
        for (int n = 0; n < 24; n++) begin
            bit          rd, pres;
            logic [4:0]  phy, rg;
            logic [15:0] wd, pd;
            rd   = $urandom_range(0, 1);
            pres = ($urandom_range(0, 3) != 0);
            phy  = 5'($urandom);
            rg   = 5'($urandom);
            wd   = 16'($urandom);
            pd   = 16'($urandom);
            run_txn(rd, pres, phy, rg, wd, pd, 1'b0, last_rd);
            if (rd) last_rd = pres ? pd : 16'h0000;
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule